// File: doc/BRIEF.md
# ALU Status Flags and Condition Evaluator

This unit sits beside the adder and logic unit of a small processor datapath. It derives the four status flags from each operation: negative, zero, carry and overflow. It holds them in a status register. The register changes only when an instruction asks for flags to be set, or when software writes it directly. Its contents are always visible on an output port, so the register can be copied back into a general register.

A 4-bit condition code is decoded every cycle against the stored flags. The result is a single pass bit that decides whether a conditional branch is taken or a conditional store executes. The decode covers the plain flag tests, the unsigned higher and lower-or-same tests, and the signed ordering tests, including the compound greater-than and less-or-equal tests.

The stored carry feeds back as the carry-in of the add-with-carry and subtract-with-carry operations, so arithmetic wider than the word can be chained one word at a time.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `flags` is 4'b0000. The flag bit positions are `flags[3]`=N, `flags[2]`=Z, `flags[1]`=C and `flags[0]`=V.
- R2: After a clock edge that samples `set_flags`=1 and `sr_wr_en`=0, N equals the most significant bit of the operation result and Z is 1 exactly when the result is all zeros.
- R3: For ADD (`op_kind`=3'b000) the result is `op_a`+`op_b`. C is the unsigned carry out. V is set when both operands have the same sign and the result sign differs from it.
- R4: For SUB (`op_kind`=3'b010) the result is `op_a`-`op_b`. C is 1 when no borrow occurs, that is, when `op_a` >= `op_b` unsigned. V is set when the operand signs differ and the result sign differs from `op_a`.
- R5: ADC (3'b001) computes `op_a`+`op_b`+C, and SBC (3'b011) computes `op_a`-`op_b`-(1-C), using the stored C as carry-in. Both set C and V with the rules of R3 and R4, so wide sums and differences chain word by word.
- R6: The logic kinds are AND (3'b100), OR (3'b101), XOR (3'b110) and PASS (3'b111, result is `op_b`). They update N and Z from their result and leave C and V unchanged.
- R7: When `set_flags` and `sr_wr_en` are both 0 at a clock edge, `flags` keeps its value, whatever the operands and kind.
- R8: When `sr_wr_en` is 1 at a clock edge, `flags` takes `sr_wr_data`, whether or not `set_flags` is also 1.
- R9: `cond_pass` is combinational from `cond` and the stored flags. Codes 0..7 are: EQ=Z, NE=!Z, CS=C, CC=!C, MI=N, PL=!N, VS=V, VC=!V.
- R10: Code 8 (HI) passes on C and !Z, and 9 (LS) passes on !C or Z. Code 10 (GE) passes on N==V, and 11 (LT) passes on N!=V.
- R11: Code 12 (GT) passes on !Z and N==V, and 13 (LE) passes on Z or N!=V.
- R12: Code 14 (AL) always passes and code 15 (NV) never passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| op_kind | input | 3 | Operation kind (see R3 to R6) |
| set_flags | input | 1 | Update flags from this operation |
| sr_wr_en | input | 1 | Direct write of the status register |
| sr_wr_data | input | 4 | Value for a direct write, {N,Z,C,V} |
| cond | input | 4 | Condition code to evaluate |
| flags | output | 4 | Stored status register {N,Z,C,V} |
| cond_pass | output | 1 | Condition evaluates true |

## Verification
The bench drives the operand boundaries where arithmetic flags change:
- all-ones plus one, which a carry-out error leaves with C clear;
- the largest positive value plus one and the most negative value minus one, which a design with a reversed borrow or wrong overflow sign test reports with V or C inverted.

It chains ADC and SBC across a word boundary. A design that ignores the stored carry produces the wrong high-word zero and carry flags.

It writes all sixteen flag patterns and sweeps every condition code over each pattern. A swapped GT/LE term or a mis-ordered encoding shows up in at least one cell.

It also tests logic operations with C and V preset, and a direct write in the same cycle as a flag update. A design that clobbers C or V, or gets the write priority backwards, shows up as a wrong stored flag.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   op_kind,
  input  logic         set_flags,
  input  logic         sr_wr_en,
  input  logic [3:0]   sr_wr_data,
  input  logic [3:0]   cond,
  output logic [3:0]   flags,
  output logic         cond_pass
);
  localparam int MSB = W - 1;

  logic         fn, fz, fc, fv;
  logic         arith, subtract, chain, cin, cout;
  logic [W-1:0] b_eff, sum, logic_res, res;
  logic         v_new;
  logic [3:0]   next_flags;

  assign {fn, fz, fc, fv} = flags;

  assign arith    = ~op_kind[2];
  assign subtract = arith & op_kind[1];
  assign chain    = arith & op_kind[0];
  assign b_eff    = subtract ? ~op_b : op_b;
  assign cin      = chain ? fc : subtract;

  assign {cout, sum} = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, cin};

  always_comb begin
    case (op_kind[1:0])
      2'b00:   logic_res = op_a & op_b;
      2'b01:   logic_res = op_a | op_b;
      2'b10:   logic_res = op_a ^ op_b;
      default: logic_res = op_b;
    endcase
  end

  assign res   = arith ? sum : logic_res;
  assign v_new = (op_a[MSB] == b_eff[MSB]) && (sum[MSB] != op_a[MSB]);

  assign next_flags = {res[MSB], ~|res,
                       arith ? cout  : fc,
                       arith ? v_new : fv};

  always_ff @(posedge clk) begin
    if (!rst_n)         flags <= 4'b0000;
    else if (sr_wr_en)  flags <= sr_wr_data;
    else if (set_flags) flags <= next_flags;
  end

  always_comb begin
    case (cond)
      4'h0:    cond_pass = fz;
      4'h1:    cond_pass = ~fz;
      4'h2:    cond_pass = fc;
      4'h3:    cond_pass = ~fc;
      4'h4:    cond_pass = fn;
      4'h5:    cond_pass = ~fn;
      4'h6:    cond_pass = fv;
      4'h7:    cond_pass = ~fv;
      4'h8:    cond_pass = fc & ~fz;
      4'h9:    cond_pass = ~fc | fz;
      4'hA:    cond_pass = (fn == fv);
      4'hB:    cond_pass = (fn != fv);
      4'hC:    cond_pass = ~fz & (fn == fv);
      4'hD:    cond_pass = fz | (fn != fv);
      4'hE:    cond_pass = 1'b1;
      default: cond_pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [2:0]   op_kind,
  input logic         set_flags,
  input logic         sr_wr_en,
  input logic [3:0]   sr_wr_data,
  input logic [3:0]   cond,
  input logic [3:0]   flags,
  input logic         cond_pass
);
  p_reset_r1: assert property (@(posedge clk) !rst_n |=> flags == 4'b0000);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_flags && !sr_wr_en) |=> $stable(flags));

  p_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_en |=> flags == $past(sr_wr_data));

  p_logic_keeps_cv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && !sr_wr_en && op_kind[2]) |=> flags[1:0] == $past(flags[1:0]));

  p_add_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && !sr_wr_en && op_kind == 3'b000 && &op_a && op_b != '0)
    |=> flags[1]);

  p_sub_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && !sr_wr_en && op_kind == 3'b010 && op_a == op_b)
    |=> (flags[2] && flags[1] && !flags[0] && !flags[3]));

  p_eq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'h0 |-> cond_pass == flags[2]);

  p_gt_le_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'hC && flags[2]) |-> !cond_pass);

  p_always_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'hE |-> cond_pass);

  p_never_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'hF |-> !cond_pass);
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_kind(op_kind),
  .set_flags(set_flags), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
  .cond(cond), .flags(flags), .cond_pass(cond_pass)
);

// File: tb/alu_flag_unit_bench.sv
module alu_flag_unit_bench;
  localparam int W = 32;
  localparam longint MOD  = 64'sd1 << W;
  localparam longint SMAX = (64'sd1 << (W - 1)) - 1;
  localparam longint SMIN = -(64'sd1 << (W - 1));

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [2:0]   op_kind = 3'b000;
  logic         set_flags = 1'b0, sr_wr_en = 1'b0;
  logic [3:0]   sr_wr_data = 4'h0, cond = 4'h0;
  logic [3:0]   flags;
  logic         cond_pass;

  int compared = 0, mismatched = 0;
  bit m_n = 0, m_z = 0, m_c = 0, m_v = 0;

  always #10 clk = ~clk;

  alu_flag_unit #(.W(W)) u_alu_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_kind(op_kind),
    .set_flags(set_flags), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .cond(cond), .flags(flags), .cond_pass(cond_pass)
  );

  function automatic longint sval(logic [W-1:0] x);
    longint u = longint'({32'b0, x});
    return x[W-1] ? u - MOD : u;
  endfunction

  function automatic bit eval_cond(logic [3:0] c);
    case (c)
      0: return m_z;            1: return !m_z;
      2: return m_c;            3: return !m_c;
      4: return m_n;            5: return !m_n;
      6: return m_v;            7: return !m_v;
      8: return m_c && !m_z;    9: return !m_c || m_z;
      10: return m_n == m_v;    11: return m_n != m_v;
      12: return !m_z && (m_n == m_v);
      13: return m_z || (m_n != m_v);
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string cond_tag(logic [3:0] c);
    if (c < 8) return "R9";
    if (c < 12) return "R10";
    if (c < 14) return "R11";
    return "R12";
  endfunction

  task automatic model_update();
    longint ua, ub, sa, sb, ures, sres;
    logic [W-1:0] r;
    if (!rst_n) begin
      {m_n, m_z, m_c, m_v} = 4'b0000;
      return;
    end
    if (sr_wr_en) begin
      {m_n, m_z, m_c, m_v} = sr_wr_data;
      return;
    end
    if (!set_flags) return;
    ua = longint'({32'b0, op_a}); ub = longint'({32'b0, op_b});
    sa = sval(op_a); sb = sval(op_b);
    case (op_kind)
      3'b000, 3'b001: begin
        ures = ua + ub + ((op_kind == 3'b001 && m_c) ? 1 : 0);
        sres = sa + sb + ((op_kind == 3'b001 && m_c) ? 1 : 0);
        r = ures[W-1:0];
        m_c = ures >= MOD;
        m_v = (sres > SMAX) || (sres < SMIN);
      end
      3'b010, 3'b011: begin
        ures = ua - ub - ((op_kind == 3'b011 && !m_c) ? 1 : 0);
        sres = sa - sb - ((op_kind == 3'b011 && !m_c) ? 1 : 0);
        r = ures[W-1:0];
        m_c = ures >= 0;
        m_v = (sres > SMAX) || (sres < SMIN);
      end
      3'b100: r = op_a & op_b;
      3'b101: r = op_a | op_b;
      3'b110: r = op_a ^ op_b;
      default: r = op_b;
    endcase
    m_n = r[W-1];
    m_z = (r == '0);
  endtask

  task automatic compare(string tag);
    logic [3:0] exp_f = {m_n, m_z, m_c, m_v};
    bit exp_p = eval_cond(cond);
    compared++;
    if (flags !== exp_f) begin
      mismatched++;
      $display("FAIL %s flags actual=%b expected=%b", tag, flags, exp_f);
    end
    compared++;
    if (cond_pass !== exp_p) begin
      mismatched++;
      $display("FAIL %s cond=%0d cond_pass actual=%b expected=%b",
               cond_tag(cond), cond, cond_pass, exp_p);
    end
  endtask

  task automatic step(input logic [2:0] k, input logic [W-1:0] a,
                      input logic [W-1:0] b, input bit sf, input bit we,
                      input logic [3:0] wd, input logic [3:0] c, input string tag);
    op_kind = k; op_a = a; op_b = b; set_flags = sf;
    sr_wr_en = we; sr_wr_data = wd; cond = c;
    @(negedge clk);
    model_update();
    compare(tag);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1: reset holds flags clear even with a write requested
    step(3'b000, '1, 32'd1, 1, 1, 4'hF, 4'h1, "R1");
    step(3'b000, '1, 32'd1, 1, 0, 4'h0, 4'h0, "R1");
    rst_n = 1'b1;
    step(3'b000, 32'd0, 32'd0, 0, 0, 4'h0, 4'h3, "R1");

    // R2 / R3
    step(3'b000, 32'd0, 32'd0, 1, 0, 4'h0, 4'h0, "R2");
    step(3'b000, 32'hFFFF_FFFF, 32'd1, 1, 0, 4'h0, 4'h2, "R3");
    step(3'b000, 32'h7FFF_FFFF, 32'd1, 1, 0, 4'h0, 4'h6, "R3");
    step(3'b000, 32'h8000_0000, 32'h8000_0000, 1, 0, 4'h0, 4'h8, "R3");
    step(3'b000, 32'h1234_5678, 32'h1111_1111, 1, 0, 4'h0, 4'hC, "R2");

    // R4
    step(3'b010, 32'd5, 32'd5, 1, 0, 4'h0, 4'h0, "R4");
    step(3'b010, 32'd3, 32'd5, 1, 0, 4'h0, 4'hB, "R4");
    step(3'b010, 32'h8000_0000, 32'd1, 1, 0, 4'h0, 4'hA, "R4");
    step(3'b010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 0, 4'h0, 4'hD, "R4");

    // R5: chained add and subtract
    step(3'b000, 32'hFFFF_FFFF, 32'd1, 1, 0, 4'h0, 4'h2, "R5");
    step(3'b001, 32'd0, 32'd0, 1, 0, 4'h0, 4'h0, "R5");
    step(3'b001, 32'hFFFF_FFFF, 32'd0, 1, 0, 4'h0, 4'h0, "R5");
    step(3'b010, 32'd0, 32'd1, 1, 0, 4'h0, 4'h3, "R5");
    step(3'b011, 32'd5, 32'd2, 1, 0, 4'h0, 4'h2, "R5");
    step(3'b011, 32'd2, 32'd2, 1, 0, 4'h0, 4'h0, "R5");

    // R6: logic ops keep C and V
    step(3'b000, 32'd0, 32'd0, 0, 1, 4'b0011, 4'h6, "R6");
    step(3'b100, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1, 0, 4'h0, 4'h0, "R6");
    step(3'b101, 32'h8000_0000, 32'd1, 1, 0, 4'h0, 4'h4, "R6");
    step(3'b110, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1, 0, 4'h0, 4'h2, "R6");
    step(3'b111, 32'd0, 32'h8000_0000, 1, 0, 4'h0, 4'h7, "R6");

    // R7: no update without enable
    step(3'b000, 32'd0, 32'd0, 0, 0, 4'h0, 4'h0, "R7");
    step(3'b010, 32'd1, 32'd9, 0, 0, 4'h0, 4'h4, "R7");

    // R8: direct write wins over flag update
    step(3'b000, 32'd0, 32'd0, 1, 1, 4'b1001, 4'h0, "R8");
    step(3'b000, 32'hFFFF_FFFF, 32'd1, 1, 1, 4'b0100, 4'h1, "R8");

    // R9..R12: every flag pattern against every condition
    for (int f = 0; f < 16; f++) begin
      step(3'b000, 32'd0, 32'd0, 0, 1, 4'(f), 4'hE, "R8");
      for (int c = 0; c < 16; c++)
        step(3'b000, 32'd7, 32'd7, 0, 0, 4'h0, 4'(c), cond_tag(4'(c)));
    end

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] a, b;
      int sel = $urandom_range(0, 3);
      a = $urandom();
      b = $urandom();
      if (sel == 0) a = b;
      if (sel == 1) a = {a[W-1], {(W-1){~a[W-1]}}};
      step(3'($urandom_range(0, 7)), a, b, bit'($urandom_range(0, 3) != 0),
           bit'($urandom_range(0, 9) == 0), 4'($urandom_range(0, 15)),
           4'($urandom_range(0, 15)), "R2");
    end

    finish_run();
  end
endmodule